// File: doc/BRIEF.md
# Branch Trace Ring Recorder

This block keeps a hardware history of the most recent taken branches. Each time the core retires a taken branch it presents a strobe together with the branch's source and destination addresses and the privilege ring it ran in. If recording is enabled, not frozen, the machine is not asleep and the ring filter lets the branch through, the block advances a newest-entry pointer around a circular buffer of 32 slots. It then stores both addresses in the slot the pointer now names. Once the buffer is full, each new record replaces the oldest one.

Software uses a small register port to set up recording and read the history back. It writes a control word and a ring filter, and reads the newest-entry pointer and every stored source and destination address. A performance-monitoring interrupt can freeze the history so that the branches leading up to the event are kept. A deep-sleep indication wipes every stored address.

Top module: `brt_recorder`

## Requirements
- R1: After reset every stored source and destination address reads zero, the newest-entry pointer reads 0, the control word reads 0 and the filter word reads 0.
- R2: An accepted branch moves the newest-entry pointer (address 0x1c9, read-only, value in the low 5 bits) forward by one. In the same cycle the slot at the new pointer value takes the branch's source address, read at 0x680 plus the slot index, and its destination address, read at 0x6c0 plus the slot index.
- R3: The pointer wraps from 31 to 0, so with the pointer starting at 0 the 33rd accepted branch overwrites the slot that holds the 1st, which is slot 1.
- R4: The control word sits at address 0x1d9. Bit 0 enables recording, and while it is 0 branch strobes change neither the pointer nor any slot.
- R5: The filter word sits at address 0x1c8 and keeps only its low two bits. With bit 0 set, branches in ring 0 are dropped. With bit 1 set, branches in any ring other than 0 are dropped. Both bits read back.
- R6: While control bit 11 is 1, a performance-interrupt pulse sets a frozen flag that reads back at control bit 12. Any branch strobe in the same cycle as the pulse, or while the flag is set, is dropped. A pulse while bit 11 is 0 has no effect.
- R7: Any write to the control word clears the frozen flag, unless a freezing pulse arrives in that same cycle, in which case the flag is set.
- R8: While the deep-sleep input is high, every slot is cleared to zero on the next clock edge and branch strobes are dropped. The pointer keeps its value.
- R9: Writes to the pointer and slot addresses have no effect. Reads of any unmapped address, including the gaps between the regions, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | One-cycle strobe: a taken branch retired |
| br_from | input | 64 | Branch source address |
| br_to | input | 64 | Branch destination address |
| cur_ring | input | 2 | Privilege ring of the retired branch |
| pmi_pulse | input | 1 | Performance-monitoring interrupt pulse |
| deep_sleep | input | 1 | High while the core is in a deep sleep state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |

## Verification
On every clock the assertions check the following: the pointer steps by one on each accepted branch and holds otherwise, it wraps from the last slot to slot 0, the slot it names takes the presented addresses, a sleep cycle leaves the slots at zero, and the frozen flag is set by a freezing pulse, stays set and is cleared by a control write. The ordering of the whole history can only be shown by the bench's scenarios. These cover the 33rd branch replacing the 1st, the interplay of the ring filter with the enable bit, branches dropped in the cycle of the interrupt, and a mixed random stream. In each case the bench compares every slot against a queue of the last 32 accepted branches.

// File: rtl/brt_pkg.sv
// Package: shared register addresses, control bit positions and the control
// state type for the branch trace recorder. Assumes a 12-bit register address.
package brt_pkg;
    localparam int unsigned REG_AW = 12;
    localparam int unsigned SEL_W  = 2;

    localparam logic [REG_AW-1:0] CTL_ADDR  = 12'h1d9;
    localparam logic [REG_AW-1:0] TOS_ADDR  = 12'h1c9;
    localparam logic [REG_AW-1:0] SEL_ADDR  = 12'h1c8;
    localparam logic [REG_AW-1:0] FROM_BASE = 12'h680;
    localparam logic [REG_AW-1:0] TO_BASE   = 12'h6c0;

    localparam int unsigned CTL_EN_BIT     = 0;
    localparam int unsigned CTL_FRZEN_BIT  = 11;
    localparam int unsigned CTL_FROZEN_BIT = 12;

    localparam int unsigned SEL_SKIP_R0  = 0;
    localparam int unsigned SEL_SKIP_OUT = 1;

    typedef struct packed {
        logic frozen;
        logic frz_on_pmi;
        logic en;
    } ctl_t;
endpackage

// File: rtl/brt_ctrl.sv
// Module: control word, ring filter and freeze flag. Decides whether the
// branch presented this cycle is accepted. Assumes the write strobes are
// already decoded from the register address.
module brt_ctrl
    import brt_pkg::*;
#(
    parameter int unsigned RING_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [RING_W-1:0] cur_ring,
    input  logic              pmi_pulse,
    input  logic              deep_sleep,
    input  logic              wr_ctl,
    input  logic              wr_sel,
    input  logic              wd_en,
    input  logic              wd_frz,
    input  logic [SEL_W-1:0]  wd_sel,
    output ctl_t              ctl,
    output logic [SEL_W-1:0]  sel,
    output logic              accept
);
    logic freeze_hit;
    logic ring_pass;

    // Purpose: detect a freezing interrupt and apply the privilege filter.
    always_comb begin
        freeze_hit = pmi_pulse & ctl.frz_on_pmi;
        ring_pass  = (cur_ring == '0) ? !sel[SEL_SKIP_R0] : !sel[SEL_SKIP_OUT];
        accept     = br_valid & ctl.en & !ctl.frozen & !freeze_hit
                   & !deep_sleep & ring_pass;
    end

    // Purpose: hold the control bits; a freezing pulse wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (wr_ctl) begin
                ctl.en         <= wd_en;
                ctl.frz_on_pmi <= wd_frz;
                ctl.frozen     <= 1'b0;
            end
            if (freeze_hit) ctl.frozen <= 1'b1;
        end
    end

    // Purpose: hold the ring filter word.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel <= '0;
        else if (wr_sel) sel <= wd_sel;
    end

    // R6
    freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmi_pulse && ctl.frz_on_pmi) |=> ctl.frozen);
    // R6
    freeze_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.frozen && !wr_ctl) |=> ctl.frozen);
    // R7
    freeze_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !(pmi_pulse && ctl.frz_on_pmi)) |=> !ctl.frozen);
endmodule

// File: rtl/brt_ring.sv
// Module: circular record store with the newest-entry pointer. On accept the
// pointer advances first and the new slot takes both addresses. Deep sleep
// clears every slot. Assumes accept is already low during sleep.
module brt_ring #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              deep_sleep,
    input  logic [ADDR_W-1:0] br_from,
    input  logic [ADDR_W-1:0] br_to,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  tos,
    output logic [ADDR_W-1:0] rd_from,
    output logic [ADDR_W-1:0] rd_to
);
    logic [ADDR_W-1:0] from_q [DEPTH];
    logic [ADDR_W-1:0] to_q   [DEPTH];
    logic [IDX_W-1:0]  tos_nx;

    // Purpose: next pointer value, wrapping after the last slot.
    always_comb begin
        tos_nx = (tos == IDX_W'(DEPTH - 1)) ? '0 : tos + 1'b1;
    end

    // Purpose: pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tos <= '0;
        else if (accept) tos <= tos_nx;
    end

    // Purpose: slot storage with sleep clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || deep_sleep) begin
            for (int i = 0; i < DEPTH; i++) begin
                from_q[i] <= '0;
                to_q[i]   <= '0;
            end
        end else if (accept) begin
            from_q[tos_nx] <= br_from;
            to_q[tos_nx]   <= br_to;
        end
    end

    // Purpose: read port for the register map.
    always_comb begin
        rd_from = from_q[rd_idx];
        rd_to   = to_q[rd_idx];
    end

    // R2
    tos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tos != IDX_W'(DEPTH - 1)) |=> (tos == $past(tos) + 1'b1));
    // R2
    tos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(tos));
    // R3
    tos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tos == IDX_W'(DEPTH - 1)) |=> (tos == '0));
    // R2
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (from_q[tos] == $past(br_from) && to_q[tos] == $past(br_to)));
    // R8
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |=> (from_q[tos] == '0 && to_q[tos] == '0
                        && from_q[0] == '0 && to_q[DEPTH-1] == '0));
endmodule

// File: rtl/brt_regmap.sv
// Module: register address decode and read multiplexer. Slot regions hold
// DEPTH words each; assumes DEPTH is at most 64 so the regions do not overlap.
module brt_regmap
    import brt_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  ctl_t              ctl,
    input  logic [SEL_W-1:0]  sel,
    input  logic [IDX_W-1:0]  tos,
    input  logic [ADDR_W-1:0] rd_from,
    input  logic [ADDR_W-1:0] rd_to,
    output logic              wr_ctl,
    output logic              wr_sel,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] reg_rdata
);
    logic [REG_AW-1:0] off_from, off_to;
    logic              hit_from, hit_to;
    logic              unused_off;

    // Purpose: locate the address inside the slot regions.
    always_comb begin
        off_from = reg_addr - FROM_BASE;
        off_to   = reg_addr - TO_BASE;
        hit_from = off_from < REG_AW'(DEPTH);
        hit_to   = off_to < REG_AW'(DEPTH);
        rd_idx   = hit_from ? off_from[IDX_W-1:0] : off_to[IDX_W-1:0];
        wr_ctl   = reg_wr && (reg_addr == CTL_ADDR);
        wr_sel   = reg_wr && (reg_addr == SEL_ADDR);
    end

    assign unused_off = ^{off_from, off_to};

    // Purpose: select the read word; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTL_ADDR) begin
            reg_rdata[CTL_EN_BIT]     = ctl.en;
            reg_rdata[CTL_FRZEN_BIT]  = ctl.frz_on_pmi;
            reg_rdata[CTL_FROZEN_BIT] = ctl.frozen;
        end else if (reg_addr == SEL_ADDR) begin
            reg_rdata[SEL_W-1:0] = sel;
        end else if (reg_addr == TOS_ADDR) begin
            reg_rdata[IDX_W-1:0] = tos;
        end else if (hit_from) begin
            reg_rdata = rd_from;
        end else if (hit_to) begin
            reg_rdata = rd_to;
        end
    end
endmodule

// File: rtl/brt_recorder.sv
// Module: top of the branch trace recorder. Ties the control, the ring store
// and the register map together. Assumes ADDR_W is at least 13 so every
// control bit fits in a register word.
module brt_recorder
    import brt_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned RING_W = 2,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_from,
    input  logic [ADDR_W-1:0] br_to,
    input  logic [RING_W-1:0] cur_ring,
    input  logic              pmi_pulse,
    input  logic              deep_sleep,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata
);
    ctl_t              ctl;
    logic [SEL_W-1:0]  sel;
    logic              accept, wr_ctl, wr_sel;
    logic [IDX_W-1:0]  tos, rd_idx;
    logic [ADDR_W-1:0] rd_from, rd_to;
    logic              unused_wbits;

    assign unused_wbits = ^{reg_wdata[ADDR_W-1:CTL_FRZEN_BIT+1],
                            reg_wdata[CTL_FRZEN_BIT-1:SEL_W]};

    brt_ctrl #(.RING_W(RING_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .cur_ring(cur_ring),
        .pmi_pulse(pmi_pulse), .deep_sleep(deep_sleep),
        .wr_ctl(wr_ctl), .wr_sel(wr_sel),
        .wd_en(reg_wdata[CTL_EN_BIT]), .wd_frz(reg_wdata[CTL_FRZEN_BIT]),
        .wd_sel(reg_wdata[SEL_W-1:0]),
        .ctl(ctl), .sel(sel), .accept(accept)
    );

    brt_ring #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .accept(accept), .deep_sleep(deep_sleep),
        .br_from(br_from), .br_to(br_to), .rd_idx(rd_idx),
        .tos(tos), .rd_from(rd_from), .rd_to(rd_to)
    );

    brt_regmap #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_map (
        .reg_wr(reg_wr), .reg_addr(reg_addr), .ctl(ctl), .sel(sel), .tos(tos),
        .rd_from(rd_from), .rd_to(rd_to), .wr_ctl(wr_ctl), .wr_sel(wr_sel),
        .rd_idx(rd_idx), .reg_rdata(reg_rdata)
    );
endmodule

// File: tb/sim_brt_recorder.sv
// Bench: behavioural model (queue of the last 32 accepted branches plus a
// pointer count) stepped on every clock and compared through the register port.
module sim_brt_recorder;
    localparam int D = 32;
    localparam logic [11:0] A_CTL = 12'h1d9, A_TOS = 12'h1c9, A_SEL = 12'h1c8;
    localparam logic [11:0] A_FROM = 12'h680, A_TO = 12'h6c0;

    typedef struct { logic [63:0] f; logic [63:0] t; } rec_t;

    logic clk = 0, rst_n = 0;
    logic br_valid = 0, pmi_pulse = 0, deep_sleep = 0, reg_wr = 0;
    logic [63:0] br_from = '0, br_to = '0, reg_wdata = '0, reg_rdata;
    logic [1:0]  cur_ring = '0;
    logic [11:0] reg_addr = A_TOS;

    int tests = 0, fails = 0;
    bit done = 0;
    rec_t q[$];
    int m_tos = 0;
    logic m_en = 0, m_frzen = 0, m_frozen = 0;
    logic [1:0] m_sel = '0;

    brt_recorder u0 (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_slot(input int idx, input bit to_side);
        for (int k = 0; k < q.size(); k++)
            if ((((m_tos - k) % D) + D) % D == idx) return to_side ? q[k].t : q[k].f;
        return '0;
    endfunction

    function automatic logic [63:0] exp_ctl();
        return {51'd0, m_frozen, m_frzen, 10'd0, m_en};
    endfunction

    // one clock with the given stimulus; pointer compared when not writing
    task automatic cyc(input logic bv, input logic [63:0] f, input logic [63:0] t,
                       input logic [1:0] rg, input logic pm, input logic sl,
                       input logic wr, input logic [11:0] ad, input logic [63:0] wd,
                       input string tag);
        logic frz, pass, acc;
        @(negedge clk);
        br_valid = bv; br_from = f; br_to = t; cur_ring = rg; pmi_pulse = pm;
        deep_sleep = sl; reg_wr = wr; reg_addr = wr ? ad : A_TOS; reg_wdata = wd;
        #1;
        if (!wr) chk({tag, " pointer R2"}, reg_rdata, 64'(m_tos));
        @(posedge clk);
        frz  = pm & m_frzen;
        pass = (rg == 2'd0) ? !m_sel[0] : !m_sel[1];
        acc  = bv & m_en & !m_frozen & !frz & !sl & pass;
        if (sl) q.delete();
        else if (acc) begin
            m_tos = (m_tos + 1) % D;
            q.push_front('{f, t});
            if (q.size() > D) void'(q.pop_back());
        end
        if (wr && ad == A_CTL) begin m_en = wd[0]; m_frzen = wd[11]; m_frozen = 0; end
        if (wr && ad == A_SEL) m_sel = wd[1:0];
        if (frz) m_frozen = 1;
    endtask

    task automatic br(input logic [63:0] f, input logic [63:0] t, input logic [1:0] rg, input string tag);
        cyc(1, f, t, rg, 0, 0, 0, A_TOS, '0, tag);
    endtask

    task automatic wreg(input logic [11:0] ad, input logic [63:0] wd);
        cyc(0, '0, '0, 0, 0, 0, 1, ad, wd, "write");
    endtask

    task automatic rd(input logic [11:0] ad, input logic [63:0] exp, input string tag);
        @(negedge clk);
        br_valid = 0; pmi_pulse = 0; deep_sleep = 0; reg_wr = 0; reg_addr = ad;
        #1;
        chk(tag, reg_rdata, exp);
        @(posedge clk);
    endtask

    task automatic dump(input string tag);
        for (int i = 0; i < D; i++) begin
            rd(A_FROM + 12'(i), exp_slot(i, 0), {tag, " source slot"});
            rd(A_TO + 12'(i), exp_slot(i, 1), {tag, " destination slot"});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        rd(A_CTL, 64'd0, "R1 control");
        rd(A_SEL, 64'd0, "R1 filter");
        rd(A_TOS, 64'd0, "R1 pointer");
        dump("R1");
        // R4 disabled: strobes ignored
        for (int n = 0; n < 3; n++) br(64'hdead_0000 + 64'(n), 64'hbeef, 2'd3, "R4 disabled");
        rd(A_TOS, 64'd0, "R4 pointer unchanged");
        dump("R4");
        // R2 basic recording
        wreg(A_CTL, 64'h1);
        rd(A_CTL, 64'h1, "R4 control readback");
        for (int n = 1; n <= 5; n++) br(64'h1000 + 64'(n), 64'h8000 + 64'(n), 2'd3, "R2");
        rd(A_FROM + 12'd5, 64'h1005, "R2 newest source");
        rd(A_TO + 12'd5, 64'h8005, "R2 newest destination");
        dump("R2");
        // R3 wrap
        for (int n = 6; n <= 35; n++) br(64'h1000 + 64'(n), 64'h8000 + 64'(n), 2'd1, "R3");
        rd(A_TOS, 64'd3, "R3 pointer after 35");
        rd(A_FROM + 12'd1, 64'h1021, "R3 33rd replaced 1st");
        rd(A_FROM + 12'd4, 64'h1004, "R3 untouched slot");
        dump("R3");
        // R5 filter
        wreg(A_SEL, 64'hfffd);
        rd(A_SEL, 64'h1, "R5 filter readback");
        for (int n = 0; n < 6; n++) br(64'h2000 + 64'(n), 64'h9000, 2'(n % 4), "R5 skip ring0");
        wreg(A_SEL, 64'h2);
        for (int n = 0; n < 6; n++) br(64'h3000 + 64'(n), 64'ha000, 2'(n % 4), "R5 skip outer");
        wreg(A_SEL, 64'h3);
        for (int n = 0; n < 4; n++) br(64'h3800 + 64'(n), 64'ha800, 2'(n), "R5 skip all");
        wreg(A_SEL, 64'h0);
        dump("R5");
        // R6 freeze, including a branch in the pulse cycle
        wreg(A_CTL, 64'h801);
        cyc(1, 64'h4000, 64'hb000, 2'd3, 1, 0, 0, A_TOS, '0, "R6 pulse cycle");
        rd(A_CTL, 64'h1801, "R6 frozen flag");
        for (int n = 0; n < 4; n++) br(64'h4100 + 64'(n), 64'hb100, 2'd3, "R6 frozen");
        dump("R6");
        // R7 control write clears
        wreg(A_CTL, 64'h801);
        rd(A_CTL, 64'h801, "R7 flag cleared");
        br(64'h4200, 64'hb200, 2'd0, "R7 recording again");
        // R6 pulse without freeze enable
        wreg(A_CTL, 64'h1);
        cyc(1, 64'h4300, 64'hb300, 2'd2, 1, 0, 0, A_TOS, '0, "R6 pulse ignored");
        rd(A_CTL, 64'h1, "R6 no freeze");
        dump("R6b");
        // R4 disable mid-stream
        wreg(A_CTL, 64'h0);
        br(64'h4400, 64'hb400, 2'd3, "R4 stopped");
        wreg(A_CTL, 64'h1);
        // R8 sleep clears, pointer kept, strobe dropped
        cyc(1, 64'h5000, 64'hc000, 2'd3, 0, 1, 0, A_TOS, '0, "R8 sleep");
        dump("R8");
        br(64'h5100, 64'hc100, 2'd3, "R8 after wake");
        dump("R8b");
        // R9 read-only and unmapped
        wreg(A_TOS, 64'h7);
        wreg(A_FROM + 12'd2, 64'h1234);
        wreg(A_TO + 12'd2, 64'h1234);
        rd(12'h100, 64'd0, "R9 unmapped low");
        rd(12'h6a0, 64'd0, "R9 gap");
        rd(12'h6e0, 64'd0, "R9 above");
        dump("R9");
        // mixed stream
        for (int n = 0; n < 400; n++) begin
            logic [63:0] f, t;
            f = {$urandom, $urandom}; t = {$urandom, $urandom};
            if ($urandom_range(0, 29) == 0)
                wreg(A_CTL, {52'd0, 1'b0, 1'($urandom), 10'd0, 1'b1});
            else
                cyc(1'($urandom), f, t, 2'($urandom), $urandom_range(0, 39) == 0,
                    $urandom_range(0, 149) == 0, 0, A_TOS, '0, "R2 mixed");
        end
        rd(A_CTL, exp_ctl(), "R6 mixed control");
        dump("R3 mixed");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired R1 actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule